// File: doc/BRIEF.md
# Control-Flow Label Checker

This unit sits beside a five-stage processor pipeline and enforces fine-grained control-flow integrity. The decode stage hands it a 3-bit operation code with a valid strobe and a 16-bit label. The pipeline itself executes label instructions as no-ops. Two kinds of CFI instruction exist. Setup instructions record a label: a forward target label goes into an internal label register, and a return label is pushed onto an external label stack through a push/pop port. Check instructions compare their operand against the recorded label.

The decode stage also reports every indirect call, indirect jump and return the program executes. After such a transfer the unit allows exactly one thing: the matching check instruction. Anything else, or a label mismatch, drives the unit into a terminal stop state and raises `halt`. Stack overflow and underflow are reported on separate exception outputs and never halt. An enable flag selects enforcement or legacy operation. When the flag is clear, the unit does nothing.

Operation codes on `in_op`: 0 plain instruction, 1 return-label setup (push), 2 return check, 3 call-target setup, 4 jump-target setup, 5 forward check, 6 indirect call/jump executed, 7 return executed.

States and transitions:

- OFF: entered on reset when the reset-time enable is 0, or on a write of 0 to the enable flag. The unit ignores every operation here.
- RUN moves to FWD_WAIT on op 6, and to RET_WAIT on op 7.
- FWD_WAIT moves back to RUN on op 5 with a matching label. Any other valid operation moves it to STOP.
- RET_WAIT moves back to RUN on op 2 with a matching top label. It also returns to RUN on op 2 with an empty stack, which raises underflow. Any other valid operation moves it to STOP.
- STOP stays in STOP. Only an enable write leaves it: a write of 1 goes to RUN and a write of 0 goes to OFF.

Top module: `cfi_guard`

## Requirements
- R1: After reset, with the reset-time enable at 1, `halt`, `stk_push`, `stk_pop`, `exc_over` and `exc_under` are all 0.
- R2: In RUN, a valid op 1 asserts `stk_push` in the same cycle with `stk_wdata` equal to `in_label`, provided `stk_full` is 0. No other operation ever asserts `stk_push`.
- R3: A valid op 1 in RUN while `stk_full` is 1 asserts `exc_over` in the same cycle, does not push, and does not halt.
- R4: Op 3 or op 4 in RUN loads the label register. Op 6 then requires op 5. An op 5 label equal to the register value returns the unit to RUN with `halt` still 0.
- R5: In FWD_WAIT, an op 5 whose label differs from the register value in any bit raises `halt` one cycle later.
- R6: Op 7 in RUN, followed by op 2 whose label equals `stk_top` with the stack non-empty, asserts `stk_pop` in that cycle and leaves `halt` at 0. An unequal label raises `halt` one cycle later without popping.
- R7: Op 2 in RET_WAIT while `stk_empty` is 1 asserts `exc_under` in the same cycle. It does not pop, does not halt, and returns the unit to RUN.
- R8: In FWD_WAIT or RET_WAIT, any valid operation other than the matching check (op 5 or op 2 respectively) raises `halt` one cycle later.
- R9: In RUN, ops 0, 2 and 5 have no effect: no push, no pop, no halt, and a following op 6 is still checked against the previously loaded label.
- R10: `halt` stays at 1 through any further operations until reset or an enable write. Writing 1 clears `halt` one cycle after the write.
- R11: While the enable flag is 0, no operation pushes, pops, raises an exception or halts.
- R12: Cycles with `in_valid` at 0 leave the state unchanged, so a pending check still applies to the next valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe from decode |
| in_op | input | 3 | Operation code |
| in_label | input | 16 | Label operand |
| en_we | input | 1 | Enable flag write strobe |
| en_wdata | input | 1 | New enable flag value |
| stk_top | input | 16 | Top entry of the label stack |
| stk_full | input | 1 | Label stack full |
| stk_empty | input | 1 | Label stack empty |
| stk_push | output | 1 | Push request |
| stk_pop | output | 1 | Pop request |
| stk_wdata | output | 16 | Label to push |
| halt | output | 1 | Stop request to the pipeline |
| exc_over | output | 1 | Push refused, stack full |
| exc_under | output | 1 | Pop refused, stack empty |

## Verification
Stack requests and exceptions are combinational responses to the operation in the same cycle. The bench samples them one time unit after driving, before the clock edge. `halt` comes from the state register and is due one clock edge after the offending operation, so the bench reads it at the falling edge that follows the rising edge. Sweeps walk every operation code through every state, and every single-bit label flip through the forward check. Each sweep pins its expectation to one of those two sampling points.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN  = 3'd0,
        OP_RSETUP = 3'd1,
        OP_RCHECK = 3'd2,
        OP_CSETUP = 3'd3,
        OP_JSETUP = 3'd4,
        OP_FCHECK = 3'd5,
        OP_XFER   = 3'd6,
        OP_RETURN = 3'd7
    } cfi_op_e;

    typedef enum logic [2:0] {
        S_OFF      = 3'd0,
        S_RUN      = 3'd1,
        S_FWD_WAIT = 3'd2,
        S_RET_WAIT = 3'd3,
        S_STOP     = 3'd4
    } cfi_state_e;

    typedef struct packed {
        logic any;
        logic rsetup;
        logic rcheck;
        logic tsetup;
        logic fcheck;
        logic xfer;
        logic rtn;
    } cfi_dec_t;

endpackage

// File: rtl/cfi_op_decode.sv
module cfi_op_decode
    import cfi_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    output cfi_dec_t   dec
);
    cfi_op_e op_e;

    always_comb begin
        op_e       = cfi_op_e'(op);
        dec        = '0;
        dec.any    = valid;
        if (valid) begin
            unique case (op_e)
                OP_PLAIN:  ;
                OP_RSETUP: dec.rsetup = 1'b1;
                OP_RCHECK: dec.rcheck = 1'b1;
                OP_CSETUP: dec.tsetup = 1'b1;
                OP_JSETUP: dec.tsetup = 1'b1;
                OP_FCHECK: dec.fcheck = 1'b1;
                OP_XFER:   dec.xfer   = 1'b1;
                OP_RETURN: dec.rtn    = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cfi_label_reg.sv
module cfi_label_reg #(
    parameter int LABEL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [LABEL_W-1:0] d,
    output logic [LABEL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/cfi_fsm.sv
module cfi_fsm
    import cfi_pkg::*;
#(
    parameter bit EN_AT_RESET = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_we,
    input  logic       en_wdata,
    input  cfi_dec_t   dec,
    input  logic       fwd_match,
    input  logic       ret_match,
    input  logic       stk_full,
    input  logic       stk_empty,
    output logic       en_q,
    output cfi_state_e state_q,
    output logic       push,
    output logic       pop,
    output logic       lsr_ld,
    output logic       exc_over,
    output logic       exc_under,
    output logic       halt
);
    localparam cfi_state_e RESET_STATE = EN_AT_RESET ? S_RUN : S_OFF;

    cfi_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
            en_q    <= EN_AT_RESET;
        end else begin
            state_q <= state_d;
            if (en_we) en_q <= en_wdata;
        end
    end

    always_comb begin
        state_d   = state_q;
        push      = 1'b0;
        pop       = 1'b0;
        lsr_ld    = 1'b0;
        exc_over  = 1'b0;
        exc_under = 1'b0;
        if (en_we) begin
            state_d = en_wdata ? S_RUN : S_OFF;
        end else if (dec.any) begin
            unique case (state_q)
                S_OFF, S_STOP: ;
                S_RUN: begin
                    if (dec.rsetup) begin
                        if (stk_full) exc_over = 1'b1;
                        else          push     = 1'b1;
                    end
                    if (dec.tsetup) lsr_ld  = 1'b1;
                    if (dec.xfer)   state_d = S_FWD_WAIT;
                    if (dec.rtn)    state_d = S_RET_WAIT;
                end
                S_FWD_WAIT: begin
                    state_d = (dec.fcheck && fwd_match) ? S_RUN : S_STOP;
                end
                S_RET_WAIT: begin
                    if (dec.rcheck && stk_empty) begin
                        exc_under = 1'b1;
                        state_d   = S_RUN;
                    end else if (dec.rcheck && ret_match) begin
                        pop     = 1'b1;
                        state_d = S_RUN;
                    end else begin
                        state_d = S_STOP;
                    end
                end
                default: state_d = S_STOP;
            endcase
        end
    end

    always_comb begin
        halt = (state_q == S_STOP);
    end
endmodule

// File: rtl/cfi_guard.sv
module cfi_guard
    import cfi_pkg::*;
#(
    parameter int LABEL_W     = 16,
    parameter bit EN_AT_RESET = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         in_op,
    input  logic [LABEL_W-1:0] in_label,
    input  logic               en_we,
    input  logic               en_wdata,
    input  logic [LABEL_W-1:0] stk_top,
    input  logic               stk_full,
    input  logic               stk_empty,
    output logic               stk_push,
    output logic               stk_pop,
    output logic [LABEL_W-1:0] stk_wdata,
    output logic               halt,
    output logic               exc_over,
    output logic               exc_under
);
    cfi_dec_t           dec;
    cfi_state_e         state_q;
    logic               en_q;
    logic               lsr_ld;
    logic [LABEL_W-1:0] lsr_q;
    logic               fwd_match;
    logic               ret_match;

    cfi_op_decode u_dec (
        .valid (in_valid),
        .op    (in_op),
        .dec   (dec)
    );

    cfi_label_reg #(.LABEL_W(LABEL_W)) u_lsr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (lsr_ld),
        .d     (in_label),
        .q     (lsr_q)
    );

    assign fwd_match = (in_label == lsr_q);
    assign ret_match = (in_label == stk_top);
    assign stk_wdata = in_label;

    cfi_fsm #(.EN_AT_RESET(EN_AT_RESET)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .dec       (dec),
        .fwd_match (fwd_match),
        .ret_match (ret_match),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .en_q      (en_q),
        .state_q   (state_q),
        .push      (stk_push),
        .pop       (stk_pop),
        .lsr_ld    (lsr_ld),
        .exc_over  (exc_over),
        .exc_under (exc_under),
        .halt      (halt)
    );
endmodule

// File: rtl/cfi_guard_chk.sv
module cfi_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic en_we,
    input logic en_wdata,
    input logic en_q,
    input logic halt,
    input logic stk_push,
    input logic stk_pop,
    input logic stk_full,
    input logic stk_empty,
    input logic exc_over,
    input logic exc_under
);
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push && stk_pop)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !stk_push); // R3
    AST_OVER_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_over |=> !halt); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> !stk_pop); // R7
    AST_UNDER_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_under |=> !halt); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !en_we) |=> halt); // R10
    AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_wdata) |=> !halt); // R10
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !(stk_push || stk_pop || exc_over || exc_under || halt)); // R11
endmodule

bind cfi_guard cfi_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .en_q      (en_q),
    .halt      (halt),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .exc_over  (exc_over),
    .exc_under (exc_under)
);

// File: tb/sim_cfi_guard.sv
module sim_cfi_guard;
    localparam int LW    = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = 3'd0;
    logic [LW-1:0] in_label = '0;
    logic          en_we = 1'b0;
    logic          en_wdata = 1'b0;
    logic [LW-1:0] stk_top;
    logic          stk_full, stk_empty;
    logic          stk_push, stk_pop;
    logic [LW-1:0] stk_wdata;
    logic          halt, exc_over, exc_under;

    int checks = 0;
    int errors = 0;

    logic [LW-1:0] mem [DEPTH];
    int            cnt = 0;

    logic s_push, s_pop, s_over, s_under;
    logic [LW-1:0] s_wdata;

    always #5 clk = ~clk;

    cfi_guard #(.LABEL_W(LW), .EN_AT_RESET(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_label(in_label), .en_we(en_we), .en_wdata(en_wdata),
        .stk_top(stk_top), .stk_full(stk_full), .stk_empty(stk_empty),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
        .halt(halt), .exc_over(exc_over), .exc_under(exc_under)
    );

    assign stk_full  = (cnt == DEPTH);
    assign stk_empty = (cnt == 0);
    assign stk_top   = (cnt == 0) ? '0 : mem[cnt-1];

    always @(posedge clk) begin
        if (!rst_n) cnt <= 0;
        else if (stk_push && cnt < DEPTH) begin
            mem[cnt] <= stk_wdata;
            cnt      <= cnt + 1;
        end else if (stk_pop && cnt > 0) cnt <= cnt - 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; en_we = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int op, input logic [LW-1:0] lab);
        in_valid = 1'b1; in_op = 3'(op); in_label = lab;
        #1;
        s_push = stk_push; s_pop = stk_pop; s_over = exc_over;
        s_under = exc_under; s_wdata = stk_wdata;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_en(input logic v);
        en_we = 1'b1; en_wdata = v;
        @(posedge clk); @(negedge clk);
        en_we = 1'b0;
    endtask

    localparam logic [LW-1:0] LA = 16'h3A5C;
    localparam logic [LW-1:0] LB = 16'hC0DE;

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(!halt && !stk_push && !stk_pop && !exc_over && !exc_under, "R1",
            {halt, stk_push, stk_pop, exc_over, exc_under}, 0);

        // R2 / R9: sweep every opcode in RUN
        for (int op = 0; op < 8; op++) begin
            do_reset();
            issue(op, LA);
            chk(s_push == (op == 1), "R2", s_push, op == 1);
            if (op == 1) chk(s_wdata == LA, "R2", s_wdata, LA);
            chk(!s_pop, "R9", s_pop, 0);
            chk(!halt, "R9", halt, 0);
        end

        // R9: stray checks in RUN keep the loaded label in force
        do_reset();
        issue(3, LA); issue(5, LB); issue(2, LB); issue(0, LB);
        chk(!halt, "R9", halt, 0);
        issue(6, 0); issue(5, LA);
        chk(!halt, "R9", halt, 0);

        // R8 / R4 / R6: every opcode in each waiting state
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 8; op++) begin
                bit good;
                do_reset();
                issue(4, LA);
                issue(1, LB);
                issue(w == 0 ? 6 : 7, 0);
                issue(op, w == 0 ? LA : LB);
                good = (w == 0) ? (op == 5) : (op == 2);
                chk(halt == !good, w == 0 ? "R8 fwd R4" : "R8 ret R6", halt, !good);
                if (w == 1) chk(s_pop == good, "R6", s_pop, good);
            end
        end

        // R5: every single-bit label flip on the forward check
        for (int b = 0; b < LW; b++) begin
            do_reset();
            issue(3, LA); issue(6, 0); issue(5, LA ^ (16'd1 << b));
            chk(halt, "R5", halt, 1);
        end

        // R6 mismatch on return check: halt, no pop
        do_reset();
        issue(1, LB); issue(7, 0); issue(2, LB ^ 16'h0100);
        chk(!s_pop, "R6", s_pop, 0);
        chk(halt, "R6", halt, 1);

        // R6 nested returns pop in order
        do_reset();
        issue(1, LA); issue(1, LB);
        issue(7, 0); issue(2, LB);
        chk(s_pop && !halt, "R6", {s_pop, halt}, 2);
        issue(7, 0); issue(2, LA);
        chk(s_pop && !halt, "R6", {s_pop, halt}, 2);

        // R3 overflow
        do_reset();
        for (int i = 0; i < DEPTH; i++) issue(1, LW'(i + 1));
        issue(1, LA);
        chk(s_over && !s_push, "R3", {s_over, s_push}, 2);
        chk(!halt, "R3", halt, 0);

        // R7 underflow
        do_reset();
        issue(7, 0); issue(2, LA);
        chk(s_under && !s_pop, "R7", {s_under, s_pop}, 2);
        chk(!halt, "R7", halt, 0);
        issue(0, 0);
        chk(!halt, "R7", halt, 0);

        // R10 halt persists, enable write clears
        do_reset();
        issue(6, 0); issue(0, 0);
        chk(halt, "R10", halt, 1);
        issue(1, LA); issue(5, 0); issue(3, 0);
        chk(halt && !s_push, "R10", {halt, s_push}, 2);
        idle(); idle();
        chk(halt, "R10", halt, 1);
        wr_en(1'b1);
        chk(!halt, "R10", halt, 0);

        // R11 disabled: nothing happens
        do_reset();
        wr_en(1'b0);
        for (int op = 0; op < 8; op++) begin
            issue(op, LA);
            chk(!(s_push || s_pop || s_over || s_under), "R11",
                {s_push, s_pop, s_over, s_under}, 0);
            issue(0, 0);
            chk(!halt, "R11", halt, 0);
        end
        wr_en(1'b1);
        chk(!halt, "R11", halt, 0);

        // R12 idle cycles keep a pending check
        do_reset();
        issue(3, LA); issue(6, 0);
        idle(); idle(); idle();
        chk(!halt, "R12", halt, 0);
        issue(5, LA);
        chk(!halt, "R12", halt, 0);
        issue(6, 0); idle(); idle();
        issue(0, 0);
        chk(halt, "R12", halt, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule